// File: doc/BRIEF.md
# Page Write Buffer and Timed Commit Controller

This block sits behind the serial protocol engine of a small byte-addressed non-volatile memory. The engine hands it a word address when a write transaction begins, then each received data byte, and finally an end-of-transaction strobe taken from the bus STOP. The bytes are collected in a 16-byte page buffer. The column index within the page advances with each byte and wraps, so a long burst overwrites its own earlier bytes. Nothing reaches the array until the strobe arrives. At that point a self-timed write cycle starts. Its length is a parameter in system clocks, and in its last cycle the whole page is committed through a masked page-wide write port.

While the write cycle runs, `busy_o` is high. The engine uses it to withhold acknowledges, which is what a master polling for completion sees. For every data byte the block returns a registered accept or refuse verdict. A write-protect input leaves address loading alone but refuses the first data byte, and a refused transaction never starts a write cycle. Only the columns that actually received a byte in the current transaction are written.

Top module: `pgw_commit_top`

## Requirements
- R1: While reset is asserted and right after it, `busy_o`, `mem_we_o`, `resp_vld_o` and `resp_ack_o` are all 0.
- R2: An accepted byte is stored at column (low 4 bits of the loaded address + number of bytes accepted since that load) mod 16. `mem_page_o` equals address bits [ADDR_W-1:4]. Column k of the page appears on `mem_data_o[8k+7:8k]`.
- R3: When more than 16 bytes are accepted in one transaction, the column wraps and the later byte replaces the earlier one in that column. Only the last value is committed.
- R4: `mem_we_o` stays 0 until a stop. A stop in a transaction with at least one accepted byte raises `busy_o` in the next cycle.
- R5: `busy_o` stays high for exactly WR_CYCLES cycles. `mem_we_o` is high only in the last of those cycles, and `busy_o` is low in the cycle after it.
- R6: Bit k of `mem_mask_o` is 1 during a commit exactly when column k received a byte since the most recent address load. An address load clears all of these marks.
- R7: With `wp_i`=1, an address load still opens the transaction, but a data byte is refused (`resp_ack_o`=0). Every later byte of that transaction is also refused, even if `wp_i` has dropped, and the following stop starts no write cycle.
- R8: A stop with no accepted byte since the last address load, or with no address load at all, starts no write cycle.
- R9: While `busy_o` is high, address loads, data bytes and stops are ignored. Bytes are refused, the cycle length is unchanged, and the commit carries the data of the finished transaction.
- R10: `resp_vld_o` pulses one cycle after each `data_valid_i`. `resp_ack_o`=1 only for a byte that arrives in an open, unrefused transaction while `wp_i`=0 and the block is not busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wp_i | input | 1 | Write protect level; 1 refuses data bytes |
| addr_load_i | input | 1 | Pulse: a write transaction starts with word address `addr_i` |
| addr_i | input | ADDR_W | Word address of the first byte |
| data_valid_i | input | 1 | Pulse: `data_i` carries a received data byte |
| data_i | input | 8 | Received data byte |
| stop_i | input | 1 | Pulse: the transaction ended with STOP |
| busy_o | output | 1 | Write cycle in progress; acknowledges must be withheld |
| resp_vld_o | output | 1 | Verdict for the byte of the previous cycle is valid |
| resp_ack_o | output | 1 | 1 = byte accepted, 0 = refused |
| mem_we_o | output | 1 | Page commit strobe to the array |
| mem_page_o | output | ADDR_W-4 | Page index of the commit |
| mem_mask_o | output | 16 | Per-column write enables of the commit |
| mem_data_o | output | 128 | Page data, column k in bits [8k+7:8k] |

## Verification
A wrong column pointer or a stale valid mark stays hidden until the commit. It then shows as a wrong byte or mask bit on the page write port, WR_CYCLES cycles after the stop. A wrong control state shows at once in the next verdict on `resp_ack_o`, or at the stop edge as a `busy_o` that rises when it should not, or fails to rise. A miscounting timer shows on the first cycle where `busy_o` or `mem_we_o` disagrees with a per-cycle reference model, which tracks busy cycles remaining, the open or refused status and the buffer contents.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  typedef enum logic [1:0] {
    PGW_IDLE    = 2'd0,
    PGW_OPEN    = 2'd1,
    PGW_REFUSED = 2'd2,
    PGW_BUSY    = 2'd3
  } pgw_state_e;
endpackage

// File: rtl/pgw_page_buf.sv
module pgw_page_buf #(
  parameter int PAGE_BYTES = 16,
  parameter int COL_W      = $clog2(PAGE_BYTES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr_i,
  input  logic                    wr_en_i,
  input  logic [COL_W-1:0]        wr_col_i,
  input  logic [7:0]              wr_data_i,
  output logic [PAGE_BYTES-1:0]   mask_o,
  output logic [PAGE_BYTES*8-1:0] data_o
);
  logic [PAGE_BYTES-1:0] vld_q;
  logic [PAGE_BYTES-1:0] vld_d;

  for (genvar k = 0; k < PAGE_BYTES; k++) begin : g_col
    logic       hit;
    logic [7:0] byte_q;
    assign hit = wr_en_i && (wr_col_i == COL_W'(k));

    always_comb begin
      vld_d[k] = vld_q[k];
      if (clr_i)    vld_d[k] = 1'b0;
      else if (hit) vld_d[k] = 1'b1;
    end

    always_ff @(posedge clk) begin
      if (hit) byte_q <= wr_data_i;
    end

    assign data_o[8*k +: 8] = byte_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  assign mask_o = vld_q;

  // R6
  valid_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (mask_o == '0));
  // R6
  valid_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !clr_i) |=> (mask_o[$past(wr_col_i)] == 1'b1));
endmodule

// File: rtl/pgw_wr_timer.sv
module pgw_wr_timer #(
  parameter int WR_CYCLES = 50,
  parameter int CNT_W     = $clog2(WR_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic busy_i,
  output logic last_o
);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WR_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign last_o = busy_i && (cnt_q == LAST_CNT);
  assign cnt_en = start_i || (busy_i && !last_o);

  always_comb begin
    cnt_d = cnt_q + 1'b1;
    if (start_i) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R5
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |-> (cnt_q <= LAST_CNT));
endmodule

// File: rtl/pgw_commit_top.sv
module pgw_commit_top #(
  parameter int ADDR_W     = 11,
  parameter int PAGE_BYTES = 16,
  parameter int WR_CYCLES  = 50,
  parameter int COL_W      = $clog2(PAGE_BYTES),
  parameter int PAGE_W     = ADDR_W - COL_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wp_i,
  input  logic                    addr_load_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    data_valid_i,
  input  logic [7:0]              data_i,
  input  logic                    stop_i,
  output logic                    busy_o,
  output logic                    resp_vld_o,
  output logic                    resp_ack_o,
  output logic                    mem_we_o,
  output logic [PAGE_W-1:0]       mem_page_o,
  output logic [PAGE_BYTES-1:0]   mem_mask_o,
  output logic [PAGE_BYTES*8-1:0] mem_data_o
);
  import pgw_pkg::*;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  pgw_state_e        state_q, state_d;
  logic [PAGE_W-1:0] page_q;
  logic [COL_W-1:0]  col_q, col_d;
  logic              resp_vld_q, resp_ack_q;
  logic              load_ok, accept, refuse, any_valid, start_wr, last_wr;

  assign load_ok  = addr_load_i && (state_q != PGW_BUSY);
  assign accept   = (state_q == PGW_OPEN) && data_valid_i && !wp_i && !addr_load_i;
  assign refuse   = (state_q == PGW_OPEN) && data_valid_i && wp_i && !addr_load_i;
  assign start_wr = (state_q != PGW_BUSY) && (state_d == PGW_BUSY);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PGW_IDLE, PGW_REFUSED: begin
        if (addr_load_i) state_d = PGW_OPEN;
        else if (stop_i) state_d = PGW_IDLE;
      end
      PGW_OPEN: begin
        if (addr_load_i)  state_d = PGW_OPEN;
        else if (refuse)  state_d = PGW_REFUSED;
        else if (stop_i)  state_d = any_valid ? PGW_BUSY : PGW_IDLE;
      end
      PGW_BUSY: begin
        if (last_wr) state_d = PGW_IDLE;
      end
      default: state_d = PGW_IDLE;
    endcase
  end

  always_comb begin
    col_d = col_q + 1'b1;
    if (load_ok) col_d = addr_i[COL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q    <= PGW_IDLE;
      resp_vld_q <= 1'b0;
      resp_ack_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      resp_vld_q <= data_valid_i;
      resp_ack_q <= accept;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      page_q <= '0;
      col_q  <= '0;
    end else begin
      if (load_ok)           page_q <= addr_i[ADDR_W-1:COL_W];
      if (load_ok || accept) col_q  <= col_d;
    end
  end

  pgw_page_buf #(.PAGE_BYTES(PAGE_BYTES), .COL_W(COL_W)) buf_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .clr_i     (load_ok),
    .wr_en_i   (accept),
    .wr_col_i  (col_q),
    .wr_data_i (data_i),
    .mask_o    (mem_mask_o),
    .data_o    (mem_data_o)
  );

  assign any_valid = |mem_mask_o;

  pgw_wr_timer #(.WR_CYCLES(WR_CYCLES)) tmr_i (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .start_i (start_wr),
    .busy_i  (state_q == PGW_BUSY),
    .last_o  (last_wr)
  );

  assign busy_o     = (state_q == PGW_BUSY);
  assign mem_we_o   = last_wr;
  assign mem_page_o = page_q;
  assign resp_vld_o = resp_vld_q;
  assign resp_ack_o = resp_ack_q;

  // R5
  we_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    mem_we_o |-> busy_o);
  // R5
  busy_ends_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    mem_we_o |=> !busy_o);
  // R5
  busy_holds_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (busy_o && !mem_we_o) |=> busy_o);
  // R4
  busy_from_stop_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(busy_o) |-> $past(stop_i));
  // R7
  wp_refuse_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    resp_ack_o |-> !$past(wp_i));
  // R10
  ack_needs_vld_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    resp_ack_o |-> resp_vld_o);
  // R9
  busy_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    resp_ack_o |-> !$past(busy_o));
  // R6
  commit_mask_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    mem_we_o |-> (mem_mask_o != '0));
  // R9
  busy_frozen_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (busy_o && !mem_we_o) |=> ($stable(mem_mask_o) && $stable(mem_page_o) && $stable(mem_data_o)));
endmodule

// File: tb/pgw_commit_top_tb.sv
module pgw_commit_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW    = 11;
  localparam int PB    = 16;
  localparam int NCYC  = 50;
  localparam int DEPTH = 1 << AW;

  logic clk, rst_n, wp, ld, dv, stp;
  logic [AW-1:0] ad;
  logic [7:0] dd;
  logic busy, rvld, rack, we;
  logic [AW-5:0] page;
  logic [PB-1:0] mask;
  logic [PB*8-1:0] data;

  pgw_commit_top #(.ADDR_W(AW), .PAGE_BYTES(PB), .WR_CYCLES(NCYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .wp_i(wp), .addr_load_i(ld), .addr_i(ad),
    .data_valid_i(dv), .data_i(dd), .stop_i(stp), .busy_o(busy),
    .resp_vld_o(rvld), .resp_ack_o(rack), .mem_we_o(we), .mem_page_o(page),
    .mem_mask_o(mask), .mem_data_o(data));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;

  byte unsigned gold [DEPTH];
  byte unsigned shad [DEPTH];
  int m_busy = 0;
  bit m_open = 0;
  int m_base = 0, m_col = 0;
  byte unsigned m_buf [PB];
  bit m_vld [PB];
  int commits = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input bit l, input int a, input bit v, input int d,
                      input bit s, input bit w);
    bit exp_ack, any;
    ld = l; ad = AW'(a); dv = v; dd = 8'(d); stp = s; wp = w;
    exp_ack = v && m_open && !w && (m_busy == 0) && !l;
    if (m_busy > 0) m_busy--;
    else if (l) begin
      m_base = a; m_col = a % PB; m_open = 1;
      foreach (m_vld[k]) m_vld[k] = 0;
    end else if (v && m_open) begin
      if (w) m_open = 0;
      else begin m_buf[m_col] = 8'(d); m_vld[m_col] = 1; m_col = (m_col + 1) % PB; end
    end else if (s) begin
      any = 0;
      foreach (m_vld[k]) any |= m_vld[k];
      if (m_open && any) m_busy = NCYC;
      m_open = 0;
    end
    @(posedge clk); #1;
    ld = 0; dv = 0; stp = 0;
    // R5 / R4 / R8 / R9: busy level against remaining count
    check(busy == (m_busy > 0), "R5", "busy_o", longint'(busy), longint'(m_busy > 0));
    // R5: commit strobe only in last busy cycle
    check(we == (m_busy == 1), "R5", "mem_we_o", longint'(we), longint'(m_busy == 1));
    // R10
    check(rvld == v, "R10", "resp_vld_o", longint'(rvld), longint'(v));
    if (v) check(rack == exp_ack, "R10", "resp_ack_o", longint'(rack), longint'(exp_ack));
    if (we && m_busy == 1) begin
      commits++;
      // R2
      check(page == AW'(m_base) >> 4, "R2", "mem_page_o", longint'(page), longint'(m_base >> 4));
      for (int k = 0; k < PB; k++) begin
        // R6
        check(mask[k] == m_vld[k], "R6", $sformatf("mask[%0d]", k), longint'(mask[k]), longint'(m_vld[k]));
        if (m_vld[k]) begin
          // R2 / R3
          check(data[8*k +: 8] == m_buf[k], "R2", $sformatf("data col %0d", k),
                longint'(data[8*k +: 8]), longint'(m_buf[k]));
          gold[(m_base & ~(PB-1)) + k] = m_buf[k];
        end
        if (mask[k]) shad[{page, 4'(k)}] = data[8*k +: 8];
      end
    end
  endtask

  task automatic idle(input int n, input bit w);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, w);
  endtask

  task automatic drain();
    while (m_busy > 0) step(0, 0, 0, 0, 0, 0);
    idle(1, 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=%0d expected<20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int c0;
    for (int i = 0; i < DEPTH; i++) begin gold[i] = 0; shad[i] = 0; end
    foreach (m_vld[k]) begin m_vld[k] = 0; m_buf[k] = 0; end
    rst_n = 0; wp = 0; ld = 0; dv = 0; stp = 0; ad = '0; dd = '0;
    repeat (3) @(posedge clk);
    #1;
    // R1
    check(busy == 0 && we == 0 && rvld == 0 && rack == 0, "R1", "outputs in reset",
          longint'({busy, we, rvld, rack}), 0);
    rst_n = 1;
    repeat (3) @(posedge clk);
    #1;
    check(busy == 0 && we == 0 && rvld == 0, "R1", "outputs after reset",
          longint'({busy, we, rvld}), 0);

    // R2 / R4: single byte write
    step(1, 'h123, 0, 0, 0, 0);
    step(0, 0, 1, 'hA5, 0, 0);
    idle(3, 0);
    check(we == 0 && busy == 0, "R4", "no write before stop", longint'({we, busy}), 0);
    step(0, 0, 0, 0, 1, 0);
    drain();

    // R2: full page from column 5
    step(1, 'h405, 0, 0, 0, 0);
    for (int i = 0; i < 16; i++) step(0, 0, 1, 'h10 + i, 0, 0);
    step(0, 0, 0, 0, 1, 0);
    drain();

    // R3: 20 bytes from column 14 wrap and overwrite
    step(1, 'h7FE, 0, 0, 0, 0);
    for (int i = 0; i < 20; i++) step(0, 0, 1, 'h80 + i, 0, 0);
    step(0, 0, 0, 0, 1, 0);
    drain();

    // R7: protected: address accepted, bytes refused, no cycle
    c0 = commits;
    step(1, 'h200, 0, 0, 0, 1);
    step(0, 0, 1, 'h55, 0, 1);
    step(0, 0, 1, 'h66, 0, 0);
    step(0, 0, 0, 0, 1, 0);
    idle(3, 0);
    check(commits == c0 && busy == 0, "R7", "no cycle after refused byte",
          longint'(commits - c0), 0);

    // R7: wp high only during address load, then low: accepted
    step(1, 'h231, 0, 0, 0, 1);
    step(0, 0, 1, 'h77, 0, 0);
    step(0, 0, 0, 0, 1, 0);
    drain();

    // R8: stop after address with no data, and stop with nothing open
    c0 = commits;
    step(1, 'h300, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 1, 0);
    step(0, 0, 1, 'h12, 0, 0);
    step(0, 0, 0, 0, 1, 0);
    idle(3, 0);
    check(commits == c0 && busy == 0, "R8", "no cycle without data",
          longint'(commits - c0), 0);

    // R9 / R6: traffic during busy ignored; second txn same page only own columns
    step(1, 'h3A2, 0, 0, 0, 0);
    step(0, 0, 1, 'hC1, 0, 0);
    step(0, 0, 1, 'hC2, 0, 0);
    step(0, 0, 0, 0, 1, 0);
    idle(5, 0);
    step(1, 'h3A9, 0, 0, 0, 0);
    step(0, 0, 1, 'hEE, 0, 0);
    step(0, 0, 0, 0, 1, 0);
    drain();
    step(1, 'h3A7, 0, 0, 0, 0);
    step(0, 0, 1, 'hD7, 0, 0);
    step(0, 0, 0, 0, 1, 0);
    drain();

    // R2 / R3 / R6: array image from commits vs model
    c0 = 0;
    for (int i = 0; i < DEPTH; i++) if (gold[i] != shad[i]) c0++;
    check(c0 == 0, "R2", "array image mismatches", c0, 0);
    check(commits == 6, "R4", "commit count", commits, 6);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule